// File: doc/BRIEF.md
# Multiplexed GPIO Port Pin Controller

This block controls an eight-pin port. Each pin is either a general-purpose I/O pin or is handed to an on-chip peripheral. Software programs three 8-bit registers through a small synchronous register interface: the pin value register, the drive-enable register and the owner register. Bit n of each register belongs to pin n. For every pin, the block drives a pad output value and a pad output enable, and it takes in the pad input level.

When a pin's owner bit is 1, the pin is under software control. Its drive-enable bit chooses between input and output. In output mode the pad drives the stored pin value. When the owner bit is 0, the peripheral owns the pin. The pad then takes its value and its enable from the peripheral side, and the drive-enable bit has no effect.

The pad input passes through a two-flop synchroniser. The synchronised level feeds the peripheral at all times. It is also what software sees when it reads the pin value register, in every mode.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the owner register reads 0xFF, the drive-enable register reads 0x00 and the stored pin value is 0x00. The pad output enables are all 0.
- R2: The register addresses are: 0 = pin value, 1 = drive enable, 2 = owner. A write with `wr_en` high updates the addressed register on the next clock edge. Reads of address 1 and address 2 return the stored contents. Any other address reads 0.
- R3: A pin with owner bit 1 and drive-enable bit 1 sets `pad_oe` to 1 and sets `pad_out` to its stored pin value bit. The values are registered with the stored bits and take effect in the cycle after the write.
- R4: A pin with owner bit 1 and drive-enable bit 0 sets `pad_oe` to 0.
- R5: A pin with owner bit 0 sets `pad_oe` equal to `mod_oe` and `pad_out` equal to `mod_dout` for that bit, combinationally. The drive-enable bit has no effect on these outputs.
- R6: `pad_in` reaches `mod_din` and `rd_data` at address 0 two clock edges after it is sampled. This holds whatever the owner and drive-enable bits are.
- R7: Reading address 0 returns the synchronised pad level, not the stored pin value. This holds even for pins in output mode.
- R8: `rd_data` is combinational from `addr` and the register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| pad_in | input | 8 | Level seen at the pads |
| pad_out | output | 8 | Value driven to the pads |
| pad_oe | output | 8 | Pad drive enable |
| mod_dout | input | 8 | Peripheral data toward the pin |
| mod_oe | input | 8 | Peripheral output enable |
| mod_din | output | 8 | Synchronised pin level toward the peripheral |

## Verification
A register write can change a pin's owner or direction in the same cycle that the pad level is moving through the synchroniser. The bench loops the pad output back to the pad input with random configurations and random peripheral drive, while writing registers on random cycles. It checks the pad outputs against a model built from the written registers. It checks every read against the loopback value from two cycles earlier.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] mod_dout,
  input  logic [W-1:0] mod_oe,
  output logic [W-1:0] mod_din
);
  logic [W-1:0] val_q, dir_q, own_q, s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0; dir_q <= '0; own_q <= '1; s1_q <= '0; s2_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      if (wr_en && addr == 2'd0) val_q <= wr_data;
      if (wr_en && addr == 2'd1) dir_q <= wr_data;
      if (wr_en && addr == 2'd2) own_q <= wr_data;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_oe[i]  = own_q[i] ? dir_q[i] : mod_oe[i];
    assign pad_out[i] = own_q[i] ? val_q[i] : mod_dout[i];
  end

  assign mod_din = s2_q;
  assign rd_data = (addr == 2'd0) ? s2_q :
                   (addr == 2'd1) ? dir_q :
                   (addr == 2'd2) ? own_q : '0;

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (own_q == '1 && dir_q == '0 && val_q == '0)); // R1
  AST_WRITE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == 2'd2) |=> own_q == $past(wr_data)); // R2
  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && addr == 2'd2) |=> $stable(own_q)); // R2
  AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (own_q[0] && dir_q[0]) |-> (pad_oe[0] && pad_out[0] == val_q[0])); // R3
  AST_GPIO_INPUT: assert property (@(posedge clk) disable iff (!rst_n) (own_q[0] && !dir_q[0]) |-> !pad_oe[0]); // R4
  AST_PERIPH_PASS: assert property (@(posedge clk) disable iff (!rst_n) !own_q[0] |-> (pad_oe[0] == mod_oe[0] && pad_out[0] == mod_dout[0])); // R5
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n, 2) |-> mod_din == $past(pad_in, 2)); // R6
endmodule

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wr_data = 0, pad_in = 0, mod_dout = 0, mod_oe = 0;
  logic [7:0] rd_data, pad_out, pad_oe, mod_din;
  logic loop = 0;
  logic [7:0] ext = 0;
  logic [7:0] m_val = 0, m_dir = 0, m_own = 8'hFF;
  logic [7:0] h1 = 0, h2 = 0;
  int n = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  gpio_mux_port u0 (.*);

  always_comb pad_in = loop ? ((pad_out & pad_oe) | (ext & ~pad_oe)) : ext;

  function automatic logic [7:0] exp_oe();
    return (m_own & m_dir) | (~m_own & mod_oe);
  endfunction

  function automatic logic [7:0] exp_out();
    return (m_own & m_val) | (~m_own & mod_dout);
  endfunction

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    n++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (a == 0) m_val = d;
    if (a == 1) m_dir = d;
    if (a == 2) m_own = d;
  endtask

  always @(posedge clk) begin
    h2 <= h1;
    h1 <= pad_in;
    cyc++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    n++;
    $display("FAIL watchdog");
    $display("== %0d vectors applied, %0d miscompares ==", n, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    addr = 2; #1 chk("R1", rd_data, 8'hFF);
    addr = 1; #1 chk("R1", rd_data, 8'h00);
    chk("R1", pad_oe, 8'h00);
    addr = 3; #1 chk("R2", rd_data, 8'h00);

    // Direct writes and readback of the register file.
    wr(1, 8'hA5); addr = 1; #1 chk("R2", rd_data, 8'hA5);
    chk("R4", pad_oe, 8'hA5);
    wr(0, 8'h3C); #1 chk("R3", pad_out & pad_oe, 8'h3C & 8'hA5);

    // Hand the upper nibble to the peripheral.
    mod_oe = 8'hF0; mod_dout = 8'h50;
    wr(2, 8'h0F); addr = 2; #1 chk("R2", rd_data, 8'h0F);
    #1 chk("R5", pad_oe, exp_oe());
    chk("R5", pad_out & pad_oe, exp_out() & exp_oe());

    // The drive-enable register has no effect on peripheral-owned pins.
    wr(1, 8'h0F); #1 chk("R5", pad_oe, exp_oe());

    // The synchroniser delay is two clocks.
    ext = 8'h99;
    @(negedge clk);
    addr = 0; #1 chk("R6", mod_din, 8'h00);
    @(negedge clk);
    #1 chk("R6", mod_din, 8'h99);
    chk("R7", rd_data, 8'h99);

    // In output mode a read returns the pad level, not the stored value.
    wr(2, 8'hFF); wr(1, 8'hFF); wr(0, 8'h12); ext = 8'h00;
    repeat (3) @(negedge clk);
    addr = 0; #1 chk("R7", rd_data, 8'h00);

    // Randomised loopback mixed with random writes.
    loop = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      ext = 8'($urandom); mod_oe = 8'($urandom); mod_dout = 8'($urandom);
      if ($urandom_range(0, 3) == 0) wr(2'($urandom_range(0, 2)), 8'($urandom));
      addr = 0;
      #1;
      chk("R5", pad_oe, exp_oe());
      chk("R3", pad_out & pad_oe, exp_out() & exp_oe());
      chk("R6", mod_din, h2);
      chk("R8", rd_data, h2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n, bad);
    $finish;
  end
endmodule